// File: doc/BRIEF.md
# Serial NOR Flash Command Engine

This block is the command side of a serial NOR flash, modelled one byte at a time over a small on-chip byte array. A bit-level SPI shifter in front of it presents each exchanged byte as a one-cycle strobe, together with the chip-select level. The engine returns exactly one response byte for every strobe. It decodes the opcode, collects a 24-bit address where the command takes one, and then reads, programs or erases the array. Programming and erasing are gated by a write-enable latch.

Every strobe is answered on the following clock with a valid flag. The response reflects the state reached after that byte has been taken in. Array depth, sector size, subsector size and page size are parameters, so the whole address map can be shrunk for simulation. All storage is reset to the erased value 0xFF.

Top module: `spinor_cmd_engine`

## Requirements
- R1: A first byte in a selection that is not one of 0x06, 0x9F, 0x05, 0x03, 0x0B, 0x02, 0xD8, 0x20 or 0xC7 is answered with 0xFF and leaves the engine waiting for an opcode, so the very next byte is decoded as an opcode.
- R2: After opcode 0x9F, the next three bytes are answered with the parameters MFR_ID, TYPE_ID and CAP_ID in that order (defaults 0x1E, 0x71, 0x0A). The byte after those three is decoded as a new opcode.
- R3: After opcode 0x05, the next byte is answered with 0x00 (never busy). The byte after that is decoded as a new opcode.
- R4: Opcode 0x03 takes three address bytes, most significant first. From the following byte onward, each byte is answered with the array byte at the address, which then increments. The array index is the address modulo DEPTH (default 1024), and it wraps from DEPTH-1 to 0.
- R5: Opcode 0x0B takes the same address bytes, then one dummy byte answered with 0xFF. Array data starts on the byte after the dummy byte.
- R6: Opcode 0x02 takes three address bytes. Each following byte is stored at the address only while the write-enable latch is set. The address then steps within its PAGE_BYTES-aligned page (default 32) and wraps to the start of the same page.
- R7: Opcodes 0xD8 and 0x20 take three address bytes. While the latch is set, they fill with 0xFF the SECTOR_BYTES (default 256) or SUBSECTOR_BYTES (default 64) aligned region that contains the address. Other bytes are untouched. With the latch clear they have no effect.
- R8: Opcode 0xC7 fills the whole array with 0xFF when the latch is set, has no effect otherwise, and returns the engine to opcode decoding.
- R9: Opcode 0x06 sets the latch, and any further byte in the same selection clears it. When chip select goes low, the engine returns to opcode decoding, and the latch is cleared unless the last opcode was 0x06.
- R10: Each strobe produces rsp_valid high for exactly one cycle, on the next clock. The response is 0xFF in opcode, address and program-data phases and whenever chip select is low. A strobe with chip select low changes no array content.
- R11: Reset fills the array with 0xFF, clears the latch and address, and sets the remembered last opcode to 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_active | input | 1 | Chip-select level, high while the device is selected |
| byte_stb | input | 1 | One-cycle strobe: a byte has been exchanged |
| byte_in | input | 8 | Byte received from the host |
| rsp_valid | output | 1 | Response byte valid, one cycle after each strobe |
| rsp_byte | output | 8 | Response byte returned to the host |

## Verification
The hardest state to reach is the write-enable latch surviving a deselect. This happens only when the lone opcode in the previous selection was 0x06, and it can only be seen later, when a program or erase either lands or does not. The stimulus therefore pairs each write-enable selection with a following program, and reads the target back after a deselect. It repeats this with a stray byte after 0x06 and with no 0x06 at all. The array-end wrap is reached by programming the last location and then fast-reading across it. Page wrap is reached by starting a program two bytes below a page boundary.

// File: rtl/spinor_pkg.sv
package spinor_pkg;

   localparam logic [7:0] OP_WREN    = 8'h06;
   localparam logic [7:0] OP_RDID    = 8'h9F;
   localparam logic [7:0] OP_RDSR    = 8'h05;
   localparam logic [7:0] OP_READ    = 8'h03;
   localparam logic [7:0] OP_FREAD   = 8'h0B;
   localparam logic [7:0] OP_PROG    = 8'h02;
   localparam logic [7:0] OP_SERASE  = 8'hD8;
   localparam logic [7:0] OP_SSERASE = 8'h20;
   localparam logic [7:0] OP_BERASE  = 8'hC7;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ID1, ST_ID2, ST_ID3, ST_WEL, ST_STAT,
      ST_ADR_HI, ST_ADR_MID, ST_ADR_LO, ST_DUMMY,
      ST_RDATA, ST_PDATA, ST_HOLD
   } eng_state_e;

   typedef enum logic [1:0] {
      ERS_NONE, ERS_SUB, ERS_SEC, ERS_ALL
   } erase_kind_e;

   function automatic logic op_known(input logic [7:0] b);
      return (b == OP_WREN) || (b == OP_RDID) || (b == OP_RDSR) ||
             (b == OP_READ) || (b == OP_FREAD) || (b == OP_PROG) ||
             (b == OP_SERASE) || (b == OP_SSERASE) || (b == OP_BERASE);
   endfunction

endpackage

// File: rtl/spinor_byte_array.sv
module spinor_byte_array
   import spinor_pkg::*;
#(
   parameter int DEPTH  = 1024,
   parameter int AW     = 10,
   parameter int SEC_LG = 8,
   parameter int SUB_LG = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_idx,
   input  logic [7:0]    wr_data,
   input  erase_kind_e   ers_kind,
   input  logic [AW-1:0] ers_idx,
   input  logic [AW-1:0] rd_idx,
   output logic [7:0]    rd_data
);

   logic [DEPTH*8-1:0] flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [AW-1:0] IDX = AW'(i);
      logic [7:0] cell_q;
      logic       hit;

      assign hit = (ers_kind == ERS_ALL) ||
                   ((ers_kind == ERS_SEC) && ((ers_idx >> SEC_LG) == (IDX >> SEC_LG))) ||
                   ((ers_kind == ERS_SUB) && ((ers_idx >> SUB_LG) == (IDX >> SUB_LG)));

      always_ff @(posedge clk) begin
         if (!rst_n)                         cell_q <= 8'hFF;
         else if (hit)                       cell_q <= 8'hFF;
         else if (wr_en && (wr_idx == IDX))  cell_q <= wr_data;
      end

      assign flat[i*8 +: 8] = cell_q;
   end

   assign rd_data = flat[rd_idx*8 +: 8];

   // R8: after a bulk erase every cell, and so any one read, is blank
   assert_bulk_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ers_kind == ERS_ALL) |=> (rd_data == 8'hFF));

endmodule

// File: rtl/spinor_cmd_fsm.sv
module spinor_cmd_fsm
   import spinor_pkg::*;
#(
   parameter int          AW      = 10,
   parameter int          PAGE_LG = 5,
   parameter logic [7:0]  MFR_ID  = 8'h1E,
   parameter logic [7:0]  TYPE_ID = 8'h71,
   parameter logic [7:0]  CAP_ID  = 8'h0A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_active,
   input  logic          byte_stb,
   input  logic [7:0]    byte_in,
   input  logic [7:0]    rd_data,
   output logic [AW-1:0] rd_idx,
   output logic          wr_en,
   output logic [AW-1:0] wr_idx,
   output logic [7:0]    wr_data,
   output erase_kind_e   ers_kind,
   output logic [AW-1:0] ers_idx,
   output logic          rsp_valid,
   output logic [7:0]    rsp_byte
);

   eng_state_e  st_q, st_d;
   logic [23:0] addr_q, addr_d;
   logic [7:0]  op_q, op_d;
   logic        wel_q, wel_d;
   logic [7:0]  rsp_d;

   always_comb begin
      st_d     = st_q;
      addr_d   = addr_q;
      op_d     = op_q;
      wel_d    = wel_q;
      rsp_d    = 8'hFF;
      wr_en    = 1'b0;
      ers_kind = ERS_NONE;

      if (!cs_active) begin
         st_d = ST_IDLE;
         if (op_q != OP_WREN) wel_d = 1'b0;
      end else if (byte_stb) begin
         unique case (st_q)
            ST_IDLE: begin
               op_d = byte_in;
               case (byte_in)
                  OP_RDID:  st_d = ST_ID1;
                  OP_WREN:  begin wel_d = 1'b1; st_d = ST_WEL; end
                  OP_RDSR:  st_d = ST_STAT;
                  OP_READ, OP_FREAD, OP_PROG, OP_SERASE, OP_SSERASE:
                            st_d = ST_ADR_HI;
                  OP_BERASE: if (wel_q) ers_kind = ERS_ALL;
                  default:  st_d = ST_IDLE;
               endcase
            end
            ST_ID1:  begin rsp_d = MFR_ID;  st_d = ST_ID2;  end
            ST_ID2:  begin rsp_d = TYPE_ID; st_d = ST_ID3;  end
            ST_ID3:  begin rsp_d = CAP_ID;  st_d = ST_IDLE; end
            ST_WEL:  wel_d = 1'b0;
            ST_STAT: begin rsp_d = 8'h00; st_d = ST_IDLE; end
            ST_ADR_HI: begin
               addr_d[23:16] = byte_in;
               st_d = ST_ADR_MID;
            end
            ST_ADR_MID: begin
               addr_d[15:8] = byte_in;
               st_d = ST_ADR_LO;
            end
            ST_ADR_LO: begin
               addr_d[7:0] = byte_in;
               case (op_q)
                  OP_READ:    st_d = ST_RDATA;
                  OP_FREAD:   st_d = ST_DUMMY;
                  OP_PROG:    st_d = ST_PDATA;
                  OP_SERASE:  begin if (wel_q) ers_kind = ERS_SEC; st_d = ST_HOLD; end
                  default:    begin if (wel_q) ers_kind = ERS_SUB; st_d = ST_HOLD; end
               endcase
            end
            ST_DUMMY: st_d = ST_RDATA;
            ST_RDATA: begin
               rsp_d = rd_data;
               if (addr_q[AW-1:0] == {AW{1'b1}}) addr_d = '0;
               else                              addr_d = addr_q + 24'd1;
            end
            ST_PDATA: begin
               wr_en  = wel_q;
               addr_d = {addr_q[23:PAGE_LG], addr_q[PAGE_LG-1:0] + PAGE_LG'(1)};
            end
            default: st_d = st_q;
         endcase
      end
   end

   assign rd_idx  = addr_q[AW-1:0];
   assign wr_idx  = addr_q[AW-1:0];
   assign wr_data = byte_in;
   assign ers_idx = addr_d[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         addr_q    <= '0;
         op_q      <= 8'hFF;
         wel_q     <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_byte  <= 8'hFF;
      end else begin
         st_q      <= st_d;
         addr_q    <= addr_d;
         op_q      <= op_d;
         wel_q     <= wel_d;
         rsp_valid <= byte_stb;
         rsp_byte  <= rsp_d;
      end
   end

   assert_unknown_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_active && byte_stb && st_q == ST_IDLE && !op_known(byte_in)) |=> (st_q == ST_IDLE));

   assert_id_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_active && byte_stb && st_q == ST_ID3) |=> (st_q == ST_IDLE));

   assert_status_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_active && byte_stb && st_q == ST_STAT) |=> (rsp_byte == 8'h00));

   assert_read_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_active && byte_stb && st_q == ST_RDATA && addr_q[AW-1:0] == {AW{1'b1}})
      |=> (addr_q == 24'd0));

   assert_page_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_active && byte_stb && st_q == ST_PDATA)
      |=> (addr_q[23:PAGE_LG] == $past(addr_q[23:PAGE_LG])));

   assert_idle_after_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active |=> (st_q == ST_IDLE));

   assert_wel_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_active && op_q != OP_WREN) |=> !wel_q);

   assert_unselected_ff_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && !cs_active) |=> (rsp_byte == 8'hFF));

endmodule

// File: rtl/spinor_cmd_engine.sv
module spinor_cmd_engine
   import spinor_pkg::*;
#(
   parameter int         DEPTH           = 1024,
   parameter int         SECTOR_BYTES    = 256,
   parameter int         SUBSECTOR_BYTES = 64,
   parameter int         PAGE_BYTES      = 32,
   parameter logic [7:0] MFR_ID          = 8'h1E,
   parameter logic [7:0] TYPE_ID         = 8'h71,
   parameter logic [7:0] CAP_ID          = 8'h0A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_active,
   input  logic       byte_stb,
   input  logic [7:0] byte_in,
   output logic       rsp_valid,
   output logic [7:0] rsp_byte
);

   localparam int AW      = $clog2(DEPTH);
   localparam int SEC_LG  = $clog2(SECTOR_BYTES);
   localparam int SUB_LG  = $clog2(SUBSECTOR_BYTES);
   localparam int PAGE_LG = $clog2(PAGE_BYTES);

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2 || AW > 24) begin : g_bad_depth
      $error("DEPTH must be a power of two between 2 and 2**24");
   end
   if ((SECTOR_BYTES & (SECTOR_BYTES - 1)) != 0 || SECTOR_BYTES >= DEPTH) begin : g_bad_sec
      $error("SECTOR_BYTES must be a power of two below DEPTH");
   end
   if ((SUBSECTOR_BYTES & (SUBSECTOR_BYTES - 1)) != 0 || SUBSECTOR_BYTES > SECTOR_BYTES) begin : g_bad_sub
      $error("SUBSECTOR_BYTES must be a power of two not above SECTOR_BYTES");
   end
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2 || PAGE_BYTES > DEPTH) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two between 2 and DEPTH");
   end

   logic [AW-1:0] rd_idx, wr_idx, ers_idx;
   logic          wr_en;
   logic [7:0]    wr_data, rd_data;
   erase_kind_e   ers_kind;

   spinor_cmd_fsm #(
      .AW(AW), .PAGE_LG(PAGE_LG),
      .MFR_ID(MFR_ID), .TYPE_ID(TYPE_ID), .CAP_ID(CAP_ID)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
      .byte_stb(byte_stb), .byte_in(byte_in), .rd_data(rd_data),
      .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .ers_kind(ers_kind), .ers_idx(ers_idx),
      .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
   );

   spinor_byte_array #(
      .DEPTH(DEPTH), .AW(AW), .SEC_LG(SEC_LG), .SUB_LG(SUB_LG)
   ) u_mem (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .ers_kind(ers_kind), .ers_idx(ers_idx),
      .rd_idx(rd_idx), .rd_data(rd_data)
   );

   assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      byte_stb |=> rsp_valid);

   assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !byte_stb |=> !rsp_valid);

endmodule

// File: tb/sim_spinor_cmd_engine.sv
`timescale 1ns/1ps
module sim_spinor_cmd_engine;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_active = 1'b0;
   logic       byte_stb = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic       rsp_valid;
   logic [7:0] rsp_byte;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   spinor_cmd_engine u0 (
      .clk(clk), .rst_n(rst_n), .cs_active(cs_active),
      .byte_stb(byte_stb), .byte_in(byte_in),
      .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
   );

   // {cs, byte sent, expected response, requirement number}
   localparam logic [20:0] VEC [62] = '{
      {1'b1, 8'h9F, 8'hFF, 4'd2},   // R2 id opcode
      {1'b1, 8'h00, 8'h1E, 4'd2},   // R2 manufacturer
      {1'b1, 8'h00, 8'h71, 4'd2},   // R2 type
      {1'b1, 8'h00, 8'h0A, 4'd2},   // R2 capacity
      {1'b1, 8'h05, 8'hFF, 4'd3},   // R3 decoded as opcode after id
      {1'b1, 8'h00, 8'h00, 4'd3},   // R3 status zero
      {1'b1, 8'hAB, 8'hFF, 4'd1},   // R1 unknown opcode
      {1'b1, 8'h05, 8'hFF, 4'd1},   // R1 still decoding
      {1'b1, 8'h00, 8'h00, 4'd1},   // R1 status came back
      {1'b0, 8'h00, 8'hFF, 4'd10},  // R10 deselect strobe
      {1'b1, 8'h06, 8'hFF, 4'd9},   // R9 lone enable
      {1'b0, 8'h00, 8'hFF, 4'd10},
      {1'b1, 8'h02, 8'hFF, 4'd10},  // program at 0x1E
      {1'b1, 8'h00, 8'hFF, 4'd10},
      {1'b1, 8'h00, 8'hFF, 4'd10},
      {1'b1, 8'h1E, 8'hFF, 4'd10},
      {1'b1, 8'h11, 8'hFF, 4'd6},   // R6 data phase answers FF
      {1'b1, 8'h22, 8'hFF, 4'd6},
      {1'b1, 8'h33, 8'hFF, 4'd6},   // lands at 0x00 via page wrap
      {1'b0, 8'h00, 8'hFF, 4'd10},
      {1'b1, 8'h03, 8'hFF, 4'd4},   // R4 read at 0
      {1'b1, 8'h00, 8'hFF, 4'd4},
      {1'b1, 8'h00, 8'hFF, 4'd4},
      {1'b1, 8'h00, 8'hFF, 4'd4},
      {1'b1, 8'h00, 8'h33, 4'd6},   // R6 wrapped byte
      {1'b1, 8'h00, 8'hFF, 4'd4},   // R4 increment to 1
      {1'b0, 8'h00, 8'hFF, 4'd10},
      {1'b1, 8'h03, 8'hFF, 4'd4},   // read at 0x1E
      {1'b1, 8'h00, 8'hFF, 4'd4},
      {1'b1, 8'h00, 8'hFF, 4'd4},
      {1'b1, 8'h1E, 8'hFF, 4'd4},
      {1'b1, 8'h00, 8'h11, 4'd6},   // R6
      {1'b1, 8'h00, 8'h22, 4'd6},
      {1'b1, 8'h00, 8'hFF, 4'd6},   // R6 next page untouched
      {1'b0, 8'h00, 8'hFF, 4'd10},
      {1'b1, 8'h02, 8'hFF, 4'd9},   // R9 latch gone after read selection
      {1'b1, 8'h00, 8'hFF, 4'd9},
      {1'b1, 8'h00, 8'hFF, 4'd9},
      {1'b1, 8'h40, 8'hFF, 4'd9},
      {1'b1, 8'h55, 8'hFF, 4'd6},
      {1'b0, 8'h00, 8'hFF, 4'd10},
      {1'b1, 8'h03, 8'hFF, 4'd4},
      {1'b1, 8'h00, 8'hFF, 4'd4},
      {1'b1, 8'h00, 8'hFF, 4'd4},
      {1'b1, 8'h40, 8'hFF, 4'd4},
      {1'b1, 8'h00, 8'hFF, 4'd6},   // R6 not stored without latch
      {1'b0, 8'h00, 8'hFF, 4'd10},
      {1'b1, 8'h06, 8'hFF, 4'd9},
      {1'b1, 8'h00, 8'hFF, 4'd9},   // R9 stray byte clears latch
      {1'b0, 8'h00, 8'hFF, 4'd10},
      {1'b1, 8'h02, 8'hFF, 4'd9},
      {1'b1, 8'h00, 8'hFF, 4'd9},
      {1'b1, 8'h00, 8'hFF, 4'd9},
      {1'b1, 8'h40, 8'hFF, 4'd9},
      {1'b1, 8'h55, 8'hFF, 4'd9},
      {1'b0, 8'h00, 8'hFF, 4'd10},
      {1'b1, 8'h03, 8'hFF, 4'd9},
      {1'b1, 8'h00, 8'hFF, 4'd9},
      {1'b1, 8'h00, 8'hFF, 4'd9},
      {1'b1, 8'h40, 8'hFF, 4'd9},
      {1'b1, 8'h00, 8'hFF, 4'd9},   // R9 program was blocked
      {1'b0, 8'h00, 8'hFF, 4'd10}
   };

   task automatic xb(input logic c, input logic [7:0] b, input logic [7:0] e, input string tag);
      @(negedge clk);
      cs_active = c;
      byte_stb  = 1'b1;
      byte_in   = b;
      @(negedge clk);
      byte_stb  = 1'b0;
      checks++;
      if (rsp_valid !== 1'b1 || rsp_byte !== e) begin
         fails++;
         $display("FAIL %s: valid=%0b rsp=%02h expected valid=1 rsp=%02h", tag, rsp_valid, rsp_byte, e);
      end
   endtask

   task automatic desel();
      xb(1'b0, 8'h00, 8'hFF, "R10");
   endtask

   task automatic cmd4(input logic [7:0] op, input logic [23:0] a, input string tag);
      xb(1'b1, op, 8'hFF, tag);
      xb(1'b1, a[23:16], 8'hFF, tag);
      xb(1'b1, a[15:8], 8'hFF, tag);
      xb(1'b1, a[7:0], 8'hFF, tag);
   endtask

   task automatic wren();
      xb(1'b1, 8'h06, 8'hFF, "R9");
      desel();
   endtask

   task automatic rd1(input logic [23:0] a, input logic [7:0] e, input string tag);
      cmd4(8'h03, a, "R4");
      xb(1'b1, 8'h00, e, tag);
      desel();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cs_active = 1'b0;
      byte_stb = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      #500000;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      checks++;   // R11 no response pending after reset
      if (rsp_valid !== 1'b0) begin
         fails++;
         $display("FAIL R11: valid=%0b expected 0", rsp_valid);
      end
      rd1(24'h0002A5, 8'hFF, "R11");   // R11 array blank after reset

      for (int k = 0; k < 62; k++) begin
         logic [20:0] v;
         v = VEC[k];
         xb(v[20], v[19:12], v[11:4], $sformatf("R%0d", v[3:0]));
      end

      // R10: idle cycle gives no valid
      @(negedge clk);
      checks++;
      if (rsp_valid !== 1'b0) begin
         fails++;
         $display("FAIL R10: idle valid=%0b expected 0", rsp_valid);
      end

      // R5 / R4: last location, fast read across the array end
      wren();
      cmd4(8'h02, 24'h0003FF, "R6");
      xb(1'b1, 8'hA5, 8'hFF, "R6");
      desel();
      cmd4(8'h0B, 24'h0003FF, "R5");
      xb(1'b1, 8'h00, 8'hFF, "R5");   // R5 dummy
      xb(1'b1, 8'h00, 8'hA5, "R5");
      xb(1'b1, 8'h00, 8'h33, "R4");   // R4 wrapped to 0
      desel();
      rd1(24'h000400, 8'h33, "R4");   // R4 index modulo depth

      // R7: subsector erase only clears its own aligned region
      wren();
      cmd4(8'h02, 24'h00003F, "R6");
      xb(1'b1, 8'h77, 8'hFF, "R6");
      desel();
      wren();
      cmd4(8'h02, 24'h000040, "R6");
      xb(1'b1, 8'h88, 8'hFF, "R6");
      desel();
      rd1(24'h000040, 8'h88, "R6");
      wren();
      cmd4(8'h20, 24'h000050, "R7");
      desel();
      cmd4(8'h03, 24'h00003F, "R7");
      xb(1'b1, 8'h00, 8'h77, "R7");
      xb(1'b1, 8'h00, 8'hFF, "R7");
      desel();

      // R7: sector erase, blocked then allowed
      cmd4(8'hD8, 24'h000010, "R7");
      desel();
      rd1(24'h000000, 8'h33, "R7");
      wren();
      cmd4(8'hD8, 24'h000080, "R7");
      desel();
      rd1(24'h000000, 8'hFF, "R7");
      rd1(24'h00003F, 8'hFF, "R7");
      rd1(24'h0003FF, 8'hA5, "R7");

      // R8: bulk erase without latch keeps data
      xb(1'b1, 8'hC7, 8'hFF, "R8");
      xb(1'b1, 8'h05, 8'hFF, "R8");   // decoded as opcode after bulk
      xb(1'b1, 8'h00, 8'h00, "R8");
      desel();
      rd1(24'h0003FF, 8'hA5, "R8");

      // R11: reset blanks array and clears latch
      wren();
      do_reset();
      rd1(24'h0003FF, 8'hFF, "R11");
      cmd4(8'h02, 24'h000200, "R11");
      xb(1'b1, 8'h66, 8'hFF, "R11");
      desel();
      rd1(24'h000200, 8'hFF, "R11");

      // R8: bulk erase with latch
      wren();
      cmd4(8'h02, 24'h000100, "R6");
      xb(1'b1, 8'h5C, 8'hFF, "R6");
      desel();
      rd1(24'h000100, 8'h5C, "R6");
      wren();
      xb(1'b1, 8'hC7, 8'hFF, "R8");
      desel();
      rd1(24'h000100, 8'hFF, "R8");

      summary();
      $finish;
   end

endmodule